// File: doc/BRIEF.md
# Clocked Request/Ready Write Bus Link

This block holds both ends of a simple write-only I/O bus: an initiator that turns write commands into bus cycles, and one addressed target that takes bytes off the bus. They are joined by three control lines (request, write, ready), an address bus and a data bus. Every bus line is a register output, so the lines change only on clock edges. A cycle has four phases:

1. The initiator drives the target address and raises request and write together.
2. The target compares the address, and raises ready only if it can take a byte.
3. The initiator places the byte on the data lines for one cycle and then drops request.
4. The target stores the byte when request falls and drops ready. The initiator waits for ready to fall before the cycle counts as complete.

If ready does not come within a set number of cycles, the initiator abandons the cycle and flags an error. In that case the target must not store anything. A mode pin selects multiplexed operation. In that mode the address also travels on the data lines, and a separate line marks the address phase.

Commands enter through a valid/ready stream. `cmd_ready` is high only while the initiator is idle, and a command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. The source must hold the command stable until then. Received bytes leave through a one-entry valid/ready stream. `rx_valid` stays high and `rx_data` stays unchanged until a cycle with `rx_ready` high. While that entry is occupied, the target counts as unavailable, which pushes back-pressure onto the bus.

Top module: `iobus_link`

## Requirements
- R1: After reset, `bus_req`, `bus_wr`, `bus_rdy`, `rx_valid`, `done` and `err` are low and `cmd_ready` is high.
- R2: One cycle after a command is accepted with `mux_mode`=0, `bus_req` and `bus_wr` are high, `bus_addr` equals the command address and `bus_is_addr` is low.
- R3: `bus_rdy` rises only one edge after `bus_req` and `bus_wr` were both high and the decoded address equals `OWN_ADDR`. A cycle to any other address never sees `bus_rdy`.
- R4: While `dev_busy` is high, or while the receive entry is occupied (`rx_valid` high), `bus_rdy` stays low and the stored byte is left unchanged.
- R5: In a cycle that completes, the byte is on `bus_data` with `bus_req` still high in the third cycle after acceptance. `bus_req` is low in the fourth, and `bus_data` holds the same byte across that fall.
- R6: The target stores `bus_data` on the edge after it sees `bus_req` low with `bus_wr` high, and drops `bus_rdy` on that same edge. `rx_valid` rises five cycles after acceptance, carrying the byte.
- R7: No new bus cycle starts while `bus_rdy` is high: `cmd_ready` and `bus_rdy` are never both high, and `bus_req` never rises while `bus_rdy` is high.
- R8: A completed cycle pulses `done` for one cycle, six cycles after acceptance and after `bus_rdy` has fallen. `done` and `err` are never high together.
- R9: If `bus_rdy` has not risen after `TIMEOUT` cycles of request, `bus_req` and `bus_wr` drop, and `err` pulses two cycles later. No byte is delivered from an abandoned cycle.
- R10: With `mux_mode`=1, the address phase puts the address on `bus_data[AW-1:0]` with `bus_is_addr`=1 and `bus_addr`=0. The data phase carries the byte with `bus_is_addr`=0, and the target decodes only while `bus_is_addr` is high.
- R11: `cmd_ready` is low from acceptance until the cycle ends. `rx_valid` with `rx_data` holds stable until taken with `rx_ready`, and one edge after that handshake `rx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mux_mode | input | 1 | 1: address carried on the data lines |
| dev_busy | input | 1 | Target device cannot accept a byte |
| cmd_valid | input | 1 | Write command offered |
| cmd_ready | output | 1 | Initiator idle, command taken this edge |
| cmd_addr | input | AW | Target address of the command |
| cmd_data | input | DW | Byte to write |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | DW | Received byte |
| done | output | 1 | One-cycle pulse: cycle completed |
| err | output | 1 | One-cycle pulse: cycle abandoned on timeout |
| bus_req | output | 1 | Request line |
| bus_wr | output | 1 | Write line |
| bus_rdy | output | 1 | Ready line from the target |
| bus_is_addr | output | 1 | Data lines carry an address (multiplexed mode) |
| bus_addr | output | AW | Address lines |
| bus_data | output | DW | Data lines |

## Verification
The main write cycle is tried with matching addresses in both the separate and the multiplexed mode. It is also tried with a non-matching address, with the device held busy, and with the receive entry still occupied. These cases separate a decode fault from an availability fault from a capture fault. Directed cases pin the exact cycle of each phase, the timeout length and the absence of any byte after an abandoned cycle. Random runs then mix addresses, bytes, modes, busy and drain decisions. This shows that the byte kept in the entry always matches the last cycle that completed.

// File: rtl/iobus_pkg.sv
package iobus_pkg;
  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_ADDR = 2'd1,
    M_DATA = 2'd2,
    M_END  = 2'd3
  } mst_state_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_HOLD = 1'b1
  } slv_state_e;
endpackage

// File: rtl/iobus_master.sv
module iobus_master
  import iobus_pkg::*;
#(
  parameter int AW      = 4,
  parameter int DW      = 8,
  parameter int TIMEOUT = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mux_mode,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          bus_rdy,
  output logic          bus_req,
  output logic          bus_wr,
  output logic          bus_is_addr,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  output logic          done,
  output logic          err
);
  localparam int CW = $clog2(TIMEOUT + 1);

  mst_state_e    state;
  logic [CW-1:0] wait_cnt;
  logic [DW-1:0] data_q;
  logic          aborted;

  assign cmd_ready = (state == M_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= M_IDLE;
      wait_cnt    <= '0;
      data_q      <= '0;
      aborted     <= 1'b0;
      bus_req     <= 1'b0;
      bus_wr      <= 1'b0;
      bus_is_addr <= 1'b0;
      bus_addr    <= '0;
      bus_data    <= '0;
      done        <= 1'b0;
      err         <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        M_IDLE: begin
          if (cmd_valid) begin
            state    <= M_ADDR;
            wait_cnt <= '0;
            aborted  <= 1'b0;
            data_q   <= cmd_data;
            bus_req  <= 1'b1;
            bus_wr   <= 1'b1;
            if (mux_mode) begin
              bus_addr    <= '0;
              bus_data    <= DW'(cmd_addr);
              bus_is_addr <= 1'b1;
            end else begin
              bus_addr    <= cmd_addr;
              bus_data    <= '0;
              bus_is_addr <= 1'b0;
            end
          end
        end
        M_ADDR: begin
          if (bus_rdy) begin
            state       <= M_DATA;
            bus_data    <= data_q;
            bus_is_addr <= 1'b0;
          end else if (wait_cnt == CW'(TIMEOUT - 1)) begin
            state       <= M_END;
            aborted     <= 1'b1;
            bus_req     <= 1'b0;
            bus_wr      <= 1'b0;
            bus_is_addr <= 1'b0;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        M_DATA: begin
          bus_req <= 1'b0;
          state   <= M_END;
        end
        M_END: begin
          if (!bus_rdy) begin
            state    <= M_IDLE;
            bus_wr   <= 1'b0;
            bus_addr <= '0;
            bus_data <= '0;
            if (aborted) err  <= 1'b1;
            else         done <= 1'b1;
          end
        end
        default: state <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iobus_addr_match.sv
module iobus_addr_match #(
  parameter int          AW       = 4,
  parameter int          DW       = 8,
  parameter logic [AW-1:0] OWN_ADDR = 4'h5
) (
  input  logic          mux_mode,
  input  logic          bus_is_addr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  output logic          hit
);
  logic sep_hit;
  logic mux_hit;

  generate
    if (DW >= AW) begin : g_wide
      assign mux_hit = bus_is_addr && (bus_data[AW-1:0] == OWN_ADDR);
    end else begin : g_narrow
      assign mux_hit = bus_is_addr && (AW'(bus_data) == OWN_ADDR);
    end
  endgenerate

  assign sep_hit = (bus_addr == OWN_ADDR);
  assign hit     = mux_mode ? mux_hit : sep_hit;
endmodule

// File: rtl/iobus_slave.sv
module iobus_slave
  import iobus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_wr,
  input  logic          addr_hit,
  input  logic [DW-1:0] bus_data,
  input  logic          dev_busy,
  output logic          bus_rdy,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data
);
  slv_state_e state;
  logic       can_take;

  assign can_take = !dev_busy && !rx_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bus_rdy  <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (bus_req && bus_wr && addr_hit && can_take) begin
            bus_rdy <= 1'b1;
            state   <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (!bus_req) begin
            bus_rdy <= 1'b0;
            state   <= S_IDLE;
            if (bus_wr) begin
              rx_data  <= bus_data;
              rx_valid <= 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iobus_link.sv
module iobus_link #(
  parameter int            AW       = 4,
  parameter int            DW       = 8,
  parameter int            TIMEOUT  = 12,
  parameter logic [AW-1:0] OWN_ADDR = 4'h5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mux_mode,
  input  logic          dev_busy,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  output logic          done,
  output logic          err,
  output logic          bus_req,
  output logic          bus_wr,
  output logic          bus_rdy,
  output logic          bus_is_addr,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data
);
  logic addr_hit;

  iobus_master #(.AW(AW), .DW(DW), .TIMEOUT(TIMEOUT)) u_master (
    .clk         (clk),
    .rst_n       (rst_n),
    .mux_mode    (mux_mode),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_addr    (cmd_addr),
    .cmd_data    (cmd_data),
    .bus_rdy     (bus_rdy),
    .bus_req     (bus_req),
    .bus_wr      (bus_wr),
    .bus_is_addr (bus_is_addr),
    .bus_addr    (bus_addr),
    .bus_data    (bus_data),
    .done        (done),
    .err         (err)
  );

  iobus_addr_match #(.AW(AW), .DW(DW), .OWN_ADDR(OWN_ADDR)) u_match (
    .mux_mode    (mux_mode),
    .bus_is_addr (bus_is_addr),
    .bus_addr    (bus_addr),
    .bus_data    (bus_data),
    .hit         (addr_hit)
  );

  iobus_slave #(.DW(DW)) u_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_wr   (bus_wr),
    .addr_hit (addr_hit),
    .bus_data (bus_data),
    .dev_busy (dev_busy),
    .bus_rdy  (bus_rdy),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data)
  );
endmodule

// File: rtl/iobus_link_chk.sv
module iobus_link_chk #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dev_busy,
  input logic          cmd_ready,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [DW-1:0] rx_data,
  input logic          done,
  input logic          err,
  input logic          bus_req,
  input logic          bus_wr,
  input logic          bus_rdy,
  input logic [DW-1:0] bus_data
);
  // R7
  rdy_owns_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !bus_rdy);
  // R7
  no_accept_during_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ready && bus_rdy));
  // R3
  rdy_after_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rdy) |-> $past(bus_req) && $past(bus_wr));
  // R4
  rdy_needs_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rdy) |-> !$past(dev_busy) && !$past(rx_valid));
  // R6
  rdy_ends_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdy && !bus_req) |=> !bus_rdy);
  // R5
  data_held_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_req) && bus_wr) |-> $stable(bus_data));
  // R11
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid && $stable(rx_data));
  // R8
  done_err_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
endmodule

bind iobus_link iobus_link_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dev_busy  (dev_busy),
  .cmd_ready (cmd_ready),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .rx_data   (rx_data),
  .done      (done),
  .err       (err),
  .bus_req   (bus_req),
  .bus_wr    (bus_wr),
  .bus_rdy   (bus_rdy),
  .bus_data  (bus_data)
);

// File: tb/iobus_link_bench.sv
module iobus_link_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int TO = 12;
  localparam logic [AW-1:0] OWN = 4'h5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mux_mode = 1'b0, dev_busy = 1'b0, cmd_valid = 1'b0, rx_ready = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic cmd_ready, rx_valid, done, err, bus_req, bus_wr, bus_rdy, bus_is_addr;
  logic [DW-1:0] rx_data, bus_data;
  logic [AW-1:0] bus_addr;

  int checks = 0;
  int failures = 0;
  bit model_full = 0;
  logic [DW-1:0] model_byte = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iobus_link #(.AW(AW), .DW(DW), .TIMEOUT(TO), .OWN_ADDR(OWN)) u_iobus_link (
    .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .dev_busy(dev_busy),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .done(done), .err(err), .bus_req(bus_req),
    .bus_wr(bus_wr), .bus_rdy(bus_rdy), .bus_is_addr(bus_is_addr),
    .bus_addr(bus_addr), .bus_data(bus_data)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit expect_accept(input logic [AW-1:0] a, input bit busy, input bit full);
    return (a == OWN) && !busy && !full;
  endfunction

  task automatic run_xfer(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit mx, input bit busy);
    bit exp_ok;
    bit full_before;
    int req_cnt, t_done, t_err, t_rx;
    bit rdy_seen;
    string why;
    full_before = model_full;
    exp_ok = expect_accept(a, busy, full_before);
    why = (a != OWN) ? "R3" : "R4";
    @(negedge clk);
    mux_mode = mx; dev_busy = busy;
    check(cmd_ready == 1'b1, "R11", "cmd_ready idle", int'(cmd_ready), 1);
    cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    check(bus_req && bus_wr, "R2", "req and wr after accept", int'({bus_req, bus_wr}), 3);
    check(cmd_ready == 1'b0, "R11", "cmd_ready busy", int'(cmd_ready), 0);
    if (mx) begin
      check(bus_is_addr && bus_data == DW'(a) && bus_addr == '0, "R10",
            "mux address phase", int'(bus_data), int'(a));
    end else begin
      check(!bus_is_addr && bus_addr == a, "R2", "address lines", int'(bus_addr), int'(a));
    end
    req_cnt = 1; t_done = -1; t_err = -1; t_rx = -1; rdy_seen = 0;
    for (int k = 2; k <= TO + 6; k++) begin
      @(posedge clk); @(negedge clk);
      if (bus_req) req_cnt++;
      if (bus_rdy) rdy_seen = 1;
      if (bus_rdy && cmd_ready) check(0, "R7", "cmd_ready with rdy", 1, 0);
      if (done && t_done < 0) t_done = k;
      if (err && t_err < 0) t_err = k;
      if (rx_valid && t_rx < 0 && !full_before) t_rx = k;
      if (exp_ok && k == 3)
        check(bus_req && !bus_is_addr && bus_data == d, "R5", "data phase byte",
              int'(bus_data), int'(d));
      if (exp_ok && k == 4)
        check(!bus_req && bus_rdy && bus_data == d, "R5", "req fall with byte held",
              int'({bus_req, bus_rdy}), 1);
    end
    check(rdy_seen == exp_ok, exp_ok ? "R3" : why, "ready seen", int'(rdy_seen), int'(exp_ok));
    if (exp_ok) begin
      check(t_done == 6, "R8", "done cycle", t_done, 6);
      check(t_err == -1, "R8", "no err", t_err, -1);
      check(t_rx == 5, "R6", "rx_valid cycle", t_rx, 5);
      check(rx_data == d, "R6", "captured byte", int'(rx_data), int'(d));
      check(req_cnt == 3, "R5", "request length", req_cnt, 3);
      model_full = 1; model_byte = d;
    end else begin
      check(t_err == TO + 2, "R9", "err cycle", t_err, TO + 2);
      check(t_done == -1, "R9", "no done", t_done, -1);
      check(req_cnt == TO, "R9", "request length on timeout", req_cnt, TO);
      check(rx_valid == full_before, "R9", "no byte from abort", int'(rx_valid), int'(full_before));
      if (full_before)
        check(rx_data == model_byte, "R4", "stored byte untouched", int'(rx_data), int'(model_byte));
    end
    dev_busy = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    check(rx_valid == model_full, "R11", "rx_valid before drain", int'(rx_valid), int'(model_full));
    if (model_full)
      check(rx_data == model_byte, "R11", "rx_data before drain", int'(rx_data), int'(model_byte));
    rx_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    rx_ready = 1'b0;
    check(rx_valid == 1'b0, "R11", "rx_valid after drain", int'(rx_valid), 0);
    model_full = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired: actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!bus_req && !bus_wr && !bus_rdy, "R1", "bus idle after reset",
          int'({bus_req, bus_wr, bus_rdy}), 0);
    check(cmd_ready && !rx_valid && !done && !err, "R1", "outputs after reset",
          int'({cmd_ready, rx_valid, done, err}), 8);

    run_xfer(OWN, 8'hA7, 1'b0, 1'b0);   // completes, separate lines
    drain();
    run_xfer(OWN, 8'h3C, 1'b1, 1'b0);   // completes, multiplexed R10
    run_xfer(OWN, 8'h11, 1'b0, 1'b0);   // entry still full: R4 timeout
    drain();
    run_xfer(4'h6, 8'h22, 1'b0, 1'b0);  // wrong address R3
    run_xfer(4'h4, 8'h33, 1'b1, 1'b0);  // wrong address, multiplexed R3
    run_xfer(OWN, 8'h44, 1'b0, 1'b1);   // device busy R4
    run_xfer(OWN, 8'hFF, 1'b1, 1'b0);
    drain();

    for (int i = 0; i < 30; i++) begin
      logic [AW-1:0] a;
      a = ($urandom() % 2 == 0) ? OWN : AW'($urandom());
      run_xfer(a, DW'($urandom()), 1'($urandom()), ($urandom() % 4) == 0);
      if (($urandom() % 10) < 7) drain();
    end
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule